// File: doc/BRIEF.md
# Two-Tier Receive Buffer Allocator

This block refills an interface receive ring with packet buffer handles. It keeps two free lists: a small private list owned by the interface, filled at reset with a fixed set of handles, and a public list that stands for the shared pool sized for the interface MTU. Each request is served from the private list while it holds a handle. When the private list is empty, the request falls back to the public list. When both are empty, the request fails, the packet is counted as ignored, and the interface is throttled for a programmable number of cycles.

Every granted handle carries a one-bit origin tag. A released handle comes back with that tag and is pushed onto the list it came from, so neither list ever holds a handle it did not start with. Both lists are last-in-first-out stacks. A release and a request that meet on the same list in one cycle are both served by passing the released handle straight to the grant.

Top module: `bufpool_alloc`

## Requirements
- R1: After reset the private list holds handles 0 to PRIV_DEPTH-1 and the public list holds handles PRIV_DEPTH to PRIV_DEPTH+PUB_DEPTH-1, each with its highest handle on top. Both counters read zero, and `gnt_o`, `fail_o` and `throttle_o` are low.
- R2: A request sampled on a clock edge is answered on the outputs registered at that same edge, so the answer is visible one cycle after `req_i`. The answer is either `gnt_o` with `gnt_handle_o` and an origin tag `gnt_pub_o` (0 = private, 1 = public), or `fail_o`. With no request, both stay low.
- R3: While the private list holds a handle, requests are granted from it with tag 0, and the fallback counter does not change.
- R4: When the private list is empty and the public list is not, the request is granted from the public list with tag 1, and `fallback_cnt_o` increments by one.
- R5: When both lists are empty, `fail_o` pulses for one cycle, no grant is given, and `ignore_cnt_o` increments by one.
- R6: A failure loads the throttle with the value of `thr_len_i` sampled at the failing request. `throttle_o` is then high for exactly that many cycles. A request made while `throttle_o` is high gets neither grant nor fail and leaves both counters unchanged.
- R7: A release pushes `rel_handle_i` onto the private list when `rel_pub_i` is 0 and onto the public list when it is 1. The next grant from that list returns the most recently released handle.
- R8: A release and a request served by the same list in one cycle are both honoured, and the grant carries the released handle. This holds even when that list was empty.
- R9: Releases are accepted while the throttle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request one buffer handle |
| thr_len_i | input | THR_W | Throttle length in cycles, sampled at a failing request |
| rel_i | input | 1 | Release a handle |
| rel_handle_i | input | HW | Handle being released |
| rel_pub_i | input | 1 | Origin tag of the released handle |
| gnt_o | output | 1 | Grant valid |
| gnt_handle_o | output | HW | Granted handle |
| gnt_pub_o | output | 1 | Origin tag of the granted handle |
| fail_o | output | 1 | Request dropped because both lists were empty |
| throttle_o | output | 1 | Throttle window active |
| fallback_cnt_o | output | CNT_W | Count of grants served from the public list |
| ignore_cnt_o | output | CNT_W | Count of dropped requests |

## Verification
A corrupted stack pointer or stack entry shows up at the first grant from that list after the fault. The handle returned then differs from the last-in-first-out order, or a grant appears where a fail was due. A wrong fallback or throttle decision shows up one cycle after the request, on the tag, on the fail pulse or on a counter step. A throttle that is off by one shows up at the edges of the `throttle_o` window. A bench model of both stacks predicts every output every cycle, so a divergence is reported within one cycle of the grant or refusal it affects.

// File: rtl/bp_pkg.sv
package bp_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PRIV = 2'd1,
        SRC_PUB  = 2'd2,
        SRC_FAIL = 2'd3
    } src_e;
endpackage

// File: rtl/bp_stack.sv
module bp_stack #(
    parameter int DEPTH = 8,
    parameter int HW    = 8,
    parameter int BASE  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [HW-1:0] push_h_i,
    input  logic          pop_i,
    output logic          avail_o,
    output logic [HW-1:0] pop_h_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][HW-1:0] mem;
        logic [CW-1:0]            cnt;
    } st_t;

    function automatic st_t init_st();
        st_t s;
        for (int i = 0; i < DEPTH; i++) s.mem[i] = HW'(BASE + i);
        s.cnt = CW'(DEPTH);
        return s;
    endfunction

    localparam st_t RST_ST = init_st();

    st_t           st_d, st_q;
    logic [CW-1:0] top_idx;
    logic          do_pop;

    assign top_idx = st_q.cnt - 1'b1;
    assign avail_o = (st_q.cnt != '0) || push_i;
    assign pop_h_o = push_i ? push_h_i
                   : ((st_q.cnt != '0) ? st_q.mem[top_idx[IW-1:0]] : '0);
    assign do_pop  = pop_i && avail_o;

    always_comb begin
        st_d = st_q;
        if (push_i && do_pop) begin
            st_d = st_q;
        end else if (push_i && (st_q.cnt < CW'(DEPTH))) begin
            st_d.mem[st_q.cnt[IW-1:0]] = push_h_i;
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (do_pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    // R8: a bypassed push/pop leaves the occupancy unchanged
    a_r8_bypass_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (st_q.cnt == $past(st_q.cnt)));

    // R3: the list never grows past its reset size
    a_r3_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && (st_q.cnt == CW'(DEPTH))) |=> (st_q.cnt == CW'(DEPTH)));
endmodule

// File: rtl/bp_throttle.sv
module bp_throttle #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] len_i,
    output logic          busy_o
);
    typedef struct packed {
        logic [TW-1:0] left;
    } st_t;

    st_t st_d, st_q;

    assign busy_o = (st_q.left != '0);

    always_comb begin
        st_d = st_q;
        if (start_i)     st_d.left = len_i;
        else if (busy_o) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the window counts down one per cycle
    a_r6_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (st_q.left == $past(st_q.left) - 1'b1));
endmodule

// File: rtl/bufpool_alloc.sv
module bufpool_alloc #(
    parameter int HW         = 8,
    parameter int PRIV_DEPTH = 8,
    parameter int PUB_DEPTH  = 8,
    parameter int CNT_W      = 16,
    parameter int THR_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [THR_W-1:0] thr_len_i,
    input  logic             rel_i,
    input  logic [HW-1:0]    rel_handle_i,
    input  logic             rel_pub_i,
    output logic             gnt_o,
    output logic [HW-1:0]    gnt_handle_o,
    output logic             gnt_pub_o,
    output logic             fail_o,
    output logic             throttle_o,
    output logic [CNT_W-1:0] fallback_cnt_o,
    output logic [CNT_W-1:0] ignore_cnt_o
);
    import bp_pkg::*;

    typedef struct packed {
        logic             gnt;
        logic [HW-1:0]    handle;
        logic             pub;
        logic             fail;
        logic [CNT_W-1:0] fb_cnt;
        logic [CNT_W-1:0] ign_cnt;
    } st_t;

    st_t           st_d, st_q;
    src_e          src;
    logic          priv_avail, pub_avail;
    logic [HW-1:0] priv_h, pub_h;
    logic          thr_busy;

    bp_stack #(.DEPTH(PRIV_DEPTH), .HW(HW), .BASE(0)) priv_stk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (rel_i && !rel_pub_i),
        .push_h_i (rel_handle_i),
        .pop_i    (src == SRC_PRIV),
        .avail_o  (priv_avail),
        .pop_h_o  (priv_h)
    );

    bp_stack #(.DEPTH(PUB_DEPTH), .HW(HW), .BASE(PRIV_DEPTH)) pub_stk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (rel_i && rel_pub_i),
        .push_h_i (rel_handle_i),
        .pop_i    (src == SRC_PUB),
        .avail_o  (pub_avail),
        .pop_h_o  (pub_h)
    );

    bp_throttle #(.TW(THR_W)) thr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (src == SRC_FAIL),
        .len_i   (thr_len_i),
        .busy_o  (thr_busy)
    );

    always_comb begin
        if (!req_i || thr_busy) src = SRC_NONE;
        else if (priv_avail)    src = SRC_PRIV;
        else if (pub_avail)     src = SRC_PUB;
        else                    src = SRC_FAIL;
    end

    always_comb begin
        st_d        = st_q;
        st_d.gnt    = 1'b0;
        st_d.fail   = 1'b0;
        st_d.pub    = 1'b0;
        st_d.handle = '0;
        case (src)
            SRC_PRIV: begin
                st_d.gnt    = 1'b1;
                st_d.handle = priv_h;
            end
            SRC_PUB: begin
                st_d.gnt    = 1'b1;
                st_d.pub    = 1'b1;
                st_d.handle = pub_h;
                st_d.fb_cnt = st_q.fb_cnt + 1'b1;
            end
            SRC_FAIL: begin
                st_d.fail    = 1'b1;
                st_d.ign_cnt = st_q.ign_cnt + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_o          = st_q.gnt;
    assign gnt_handle_o   = st_q.handle;
    assign gnt_pub_o      = st_q.pub;
    assign fail_o         = st_q.fail;
    assign throttle_o     = thr_busy;
    assign fallback_cnt_o = st_q.fb_cnt;
    assign ignore_cnt_o   = st_q.ign_cnt;

    // R2: no request, no answer
    a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!gnt_o && !fail_o));

    // R2: grant and fail never together
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(gnt_o && fail_o));

    // R3: private list preferred
    a_r3_private_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !throttle_o && priv_avail) |=> (gnt_o && !gnt_pub_o));

    // R4: each public grant bumps the fallback count
    a_r4_fallback_step: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o && gnt_pub_o) |-> (fallback_cnt_o == $past(fallback_cnt_o) + 1'b1));

    // R5: each failure bumps the ignore count
    a_r5_ignore_step: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (ignore_cnt_o == $past(ignore_cnt_o) + 1'b1));

    // R6: refusal while throttled
    a_r6_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (throttle_o && req_i) |=> (!gnt_o && !fail_o));

    // R6: a failure with nonzero length opens the window
    a_r6_start: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && ($past(thr_len_i) != '0)) |-> throttle_o);
endmodule

// File: tb/bufpool_alloc_tb_top.sv
module bufpool_alloc_tb_top;
    localparam int HW = 8, P = 8, U = 8, CW = 16, TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [TW-1:0] thr_len_i = '0;
    logic          rel_i = 1'b0;
    logic [HW-1:0] rel_handle_i = '0;
    logic          rel_pub_i = 1'b0;
    logic          gnt_o, gnt_pub_o, fail_o, throttle_o;
    logic [HW-1:0] gnt_handle_o;
    logic [CW-1:0] fallback_cnt_o, ignore_cnt_o;

    always #5 clk = ~clk;

    bufpool_alloc #(.HW(HW), .PRIV_DEPTH(P), .PUB_DEPTH(U), .CNT_W(CW), .THR_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .thr_len_i(thr_len_i),
        .rel_i(rel_i), .rel_handle_i(rel_handle_i), .rel_pub_i(rel_pub_i),
        .gnt_o(gnt_o), .gnt_handle_o(gnt_handle_o), .gnt_pub_o(gnt_pub_o),
        .fail_o(fail_o), .throttle_o(throttle_o),
        .fallback_cnt_o(fallback_cnt_o), .ignore_cnt_o(ignore_cnt_o)
    );

    int n_tests = 0, n_fail = 0;
    int pstk[32]; int pc;
    int ustk[32]; int uc;
    int hh[64]; int ht[64]; int hn;
    int thr, fb, ign;
    int eg, eh, ep, ef;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit rq, bit rl, int rh, bit rp, int len, string tag);
        req_i = rq; rel_i = rl; rel_handle_i = HW'(rh); rel_pub_i = rp;
        thr_len_i = TW'(len);
        if (rl) begin
            if (rp) begin ustk[uc] = rh; uc++; end
            else    begin pstk[pc] = rh; pc++; end
        end
        eg = 0; ef = 0; eh = 0; ep = 0;
        if (thr > 0) thr--;
        else if (rq) begin
            if (pc > 0)      begin pc--; eh = pstk[pc]; eg = 1; end
            else if (uc > 0) begin uc--; eh = ustk[uc]; eg = 1; ep = 1; fb++; end
            else             begin ef = 1; ign++; thr = len; end
        end
        if (eg != 0) begin hh[hn] = eh; ht[hn] = ep; hn++; end
        @(posedge clk);
        @(negedge clk);
        req_i = 0; rel_i = 0;
        chk(tag, "gnt", int'(gnt_o), eg);
        if (eg != 0) begin
            chk(tag, "handle", int'(gnt_handle_o), eh);
            chk(tag, "tag", int'(gnt_pub_o), ep);
        end
        chk(tag, "fail", int'(fail_o), ef);
        chk(tag, "throttle", int'(throttle_o), int'(thr != 0));
        chk(tag, "fallback", int'(fallback_cnt_o), fb);
        chk(tag, "ignore", int'(ignore_cnt_o), ign);
    endtask

    task automatic take(int i, output int h, output bit p);
        h = hh[i]; p = ht[i] != 0;
        hn--; hh[i] = hh[hn]; ht[i] = ht[hn];
    endtask

    function automatic int find_tag(int t);
        for (int i = 0; i < hn; i++) if (ht[i] == t) return i;
        return -1;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int h; bit p; int idx;
        void'($urandom(32'd1234));
        for (int i = 0; i < P; i++) pstk[i] = i;
        for (int i = 0; i < U; i++) ustk[i] = P + i;
        pc = P; uc = U; hn = 0; thr = 0; fb = 0; ign = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "gnt", int'(gnt_o), 0);
        chk("R1", "fail", int'(fail_o), 0);
        chk("R1", "throttle", int'(throttle_o), 0);
        chk("R1", "fallback", int'(fallback_cnt_o), 0);
        chk("R1", "ignore", int'(ignore_cnt_o), 0);
        step(0, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R1");
        for (int i = 1; i < P; i++) step(1, 0, 0, 0, 0, "R3");
        for (int i = 0; i < U; i++) step(1, 0, 0, 0, 0, "R4");
        step(1, 0, 0, 0, 3, "R5");
        step(1, 0, 0, 0, 3, "R6");
        idx = find_tag(0); take(idx, h, p);
        step(1, 1, h, p, 3, "R9");
        step(1, 0, 0, 0, 3, "R6");
        step(1, 0, 0, 0, 0, "R7");
        idx = find_tag(1); take(idx, h, p);
        step(1, 1, h, p, 0, "R8");
        while (hn > 0) begin take(0, h, p); step(0, 1, h, p, 0, "R7"); end
        for (int c = 0; c < 4000; c++) begin
            bit rq, rl; int len;
            rq = ($urandom % 3) != 0;
            rl = (hn > 0) && (($urandom % 5) < 2);
            len = $urandom % 6;
            h = 0; p = 0;
            if (rl) begin idx = $urandom % hn; take(idx, h, p); end
            step(rq, rl, h, p, len, "R2");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule